// File: doc/BRIEF.md
# Multi-Policy Shared Bus Arbiter

This block decides which of N processors owns a single shared bus. Each processor has a request line and receives a grant line. A shared busy line, driven by the current owner, tells the arbiter that a transfer is still in progress. The arbiter only looks at requests when the bus is idle, meaning no grant is active and busy is low. It then issues exactly one grant and holds it until the owner has dropped both its request and busy.

A two-bit select input picks the priority policy. The first policy is simple rotation, in which every priority level steps down one place after each grant. The second is least-recently-used ordering. The third is random selection with equal chance, driven by a free-running 16-bit LFSR. The rotation pointer and the usage order are both updated on every grant, whatever policy is selected. This keeps their state coherent when the policy changes between arbitrations.

Top module: `bus_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle.
- R2: An arbitration happens at a rising clock edge where `gnt` is all zero, `busy` is low and at least one `req` bit is high. The resulting grant is visible after that edge and goes to a processor whose request was high at that edge.
- R3: While `busy` is high and no grant is active, `gnt` stays all zero whatever the requests are.
- R4: An active grant stays unchanged while `busy` is high or the owner's request is high. At the first edge where both are low, `gnt` becomes all zero.
- R5: After reset `gnt` is all zero. With no request pending, `gnt` stays all zero.
- R6: In rotating mode (`mode` 2'b00, and also 2'b11), the grant goes to the first pending requester found by searching upward and cyclically from a pointer. The pointer resets to 0. On every grant, in any mode, the pointer becomes (pointer - 1) mod N, so the former lowest-priority requester becomes highest. With all N requesting, N consecutive grants serve each requester exactly once.
- R7: In LRU mode (`mode` 2'b01), the grant goes to the pending requester that appears earliest in a usage list. The list resets to 0, 1, ..., N-1, with the earliest entry being the least recently used. On every grant, in any mode, the granted index moves to the end of the list and the other entries keep their relative order.
- R8: In random mode (`mode` 2'b10), the grant goes to the first pending requester at or after a start index, searching cyclically. The start index is the LFSR value mod N. With all N requesting, each requester wins a roughly equal share of grants (between 50 and 150 of 400 for N=4).
- R9: `mode` is sampled only at arbitration edges. A change made while no grant is active governs the next arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Policy select: 00 rotate, 01 LRU, 10 random, 11 rotate |
| req | input | N | One request line per processor |
| busy | input | 1 | Bus in use by the current owner |
| gnt | output | N | One-hot grant, registered |

## Verification
Every result is a registered output. A new grant appears one edge after an idle edge with requests, and a release clears the grant one edge after the owner drops both busy and its request. Hold and blocking persist for as long as their condition holds. The bench changes inputs on the falling edge and samples `gnt` on the next falling edge, which is exactly one register stage later. For this reason each expected grant is compared half a cycle after the edge that produced it. The rotating and LRU outcomes come from a bench model of the pointer and the usage list, which is advanced from the observed grant index after every transaction. Random mode is judged only by membership in the request set and by the spread of grants across requesters.

// File: rtl/arb_pkg.sv
// Package: shared policy encoding for the bus arbiter.
// Assumes: two-bit mode input; unused code 2'b11 behaves as rotating.
package arb_pkg;
    typedef enum logic [1:0] {
        POL_ROTATE = 2'b00,
        POL_LRU    = 2'b01,
        POL_RANDOM = 2'b10,
        POL_ROT_B  = 2'b11
    } policy_e;
endpackage

// File: rtl/arb_pick.sv
// Cyclic first-pending picker: returns the one-hot of the first set request
// found searching upward from start and wrapping at N.
// Assumes: start < N.
module arb_pick #(
    parameter int N    = 4,
    parameter int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    req,
    input  logic [IDXW-1:0] start,
    output logic [N-1:0]    onehot
);
    // Purpose: scan requests cyclically from start and mark the first one.
    always_comb begin
        logic found;
        int   j;
        onehot = '0;
        found  = 1'b0;
        for (int k = 0; k < N; k++) begin
            j = int'(start) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                onehot[j] = 1'b1;
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_lfsr.sv
// Free-running Galois LFSR for random start selection.
// Assumes: TAPS gives a maximal-length sequence for W; SEED nonzero.
module arb_lfsr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    // Purpose: advance the LFSR every clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= SEED;
        else if (value[0]) value <= (value >> 1) ^ TAPS;
        else value <= value >> 1;
    end
endmodule

// File: rtl/arb_rotate.sv
// Rotating priority pointer: names the highest-priority index; on each
// grant it steps down by one so the former lowest becomes highest.
// Assumes: adv pulses for one cycle per grant.
module arb_rotate #(
    parameter int N    = 4,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [IDXW-1:0] top_idx
);
    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

    // Purpose: hold and rotate the highest-priority pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) top_idx <= '0;
        else if (adv) top_idx <= (top_idx == '0) ? LAST : top_idx - 1'b1;
    end
endmodule

// File: rtl/arb_lru.sv
// Least-recently-used order: slot 0 holds the least recently granted index,
// slot N-1 the most recent. Picks the earliest pending entry and, on each
// grant, moves the granted index to the last slot.
// Assumes: win_idx is valid whenever adv is high.
module arb_lru #(
    parameter int N    = 4,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic            adv,
    input  logic [IDXW-1:0] win_idx,
    output logic [N-1:0]    onehot
);
    logic [IDXW-1:0] order_q [N];
    logic [IDXW-1:0] win_pos;

    // Purpose: select the pending requester earliest in the order.
    always_comb begin
        logic found;
        onehot = '0;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && req[order_q[i]]) begin
                onehot[order_q[i]] = 1'b1;
                found              = 1'b1;
            end
        end
    end

    // Purpose: locate the slot holding the granted index.
    always_comb begin
        win_pos = '0;
        for (int i = 0; i < N; i++) begin
            if (order_q[i] == win_idx) win_pos = IDXW'(i);
        end
    end

    for (genvar s = 0; s < N; s++) begin : g_slot
        if (s < N - 1) begin : g_mid
            // Purpose: slots at or after the winner take their successor.
            always_ff @(posedge clk) begin
                if (!rst_n) order_q[s] <= IDXW'(s);
                else if (adv && (IDXW'(s) >= win_pos)) order_q[s] <= order_q[s+1];
            end
        end else begin : g_end
            // Purpose: last slot receives the index just granted.
            always_ff @(posedge clk) begin
                if (!rst_n) order_q[s] <= IDXW'(s);
                else if (adv) order_q[s] <= win_idx;
            end
        end
    end
endmodule

// File: rtl/bus_arbiter.sv
// Shared bus arbiter with a request/grant/busy handshake and three policies.
// Arbitrates only when no grant is active and busy is low; holds the grant
// until the owner drops both busy and its request.
// Assumes: mode changes only while no grant is active; synchronous inputs.
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int N      = 4,
    parameter int LFSR_W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [N-1:0] req,
    input  logic         busy,
    output logic [N-1:0] gnt
);
    localparam int IDXW = (N > 1) ? $clog2(N) : 1;

    logic [IDXW-1:0]   rot_top;
    logic [IDXW-1:0]   rnd_start;
    logic [LFSR_W-1:0] lfsr_val;
    logic [N-1:0]      rot_pick, rnd_pick, lru_pick, winner;
    logic [IDXW-1:0]   win_idx;
    logic              arb_go;
    logic              release_now;

    arb_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .value(lfsr_val));

    arb_rotate #(.N(N), .IDXW(IDXW)) u_rot (
        .clk(clk), .rst_n(rst_n), .adv(arb_go), .top_idx(rot_top)
    );

    assign rnd_start = IDXW'(lfsr_val % LFSR_W'(N));

    arb_pick #(.N(N), .IDXW(IDXW)) u_pick_rot (.req(req), .start(rot_top), .onehot(rot_pick));
    arb_pick #(.N(N), .IDXW(IDXW)) u_pick_rnd (.req(req), .start(rnd_start), .onehot(rnd_pick));

    arb_lru #(.N(N), .IDXW(IDXW)) u_lru (
        .clk(clk), .rst_n(rst_n), .req(req), .adv(arb_go),
        .win_idx(win_idx), .onehot(lru_pick)
    );

    // Purpose: choose the winner of the selected policy.
    always_comb begin
        unique case (policy_e'(mode))
            POL_LRU:    winner = lru_pick;
            POL_RANDOM: winner = rnd_pick;
            default:    winner = rot_pick;
        endcase
    end

    // Purpose: encode the winning one-hot as an index.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (winner[i]) win_idx = IDXW'(i);
        end
    end

    assign arb_go      = (gnt == '0) && !busy && (req != '0);
    assign release_now = (gnt != '0) && !busy && ((gnt & req) == '0);

    // Purpose: register the grant, holding it through the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) gnt <= '0;
        else if (arb_go) gnt <= winner;
        else if (release_now) gnt <= '0;
    end
endmodule

// File: rtl/arb_checker.sv
// Checker for the bus arbiter handshake, bound to every bus_arbiter instance.
// Assumes: synchronous active-low reset shared with the design.
module arb_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req,
    input logic         busy,
    input logic [N-1:0] gnt
);
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R1

    AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && !busy && req != '0) |=> ((gnt & $past(req)) != '0)); // R2

    AST_NO_GNT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && busy) |=> (gnt == '0)); // R3

    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && (busy || (gnt & req) != '0)) |=> $stable(gnt)); // R4

    AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && !busy && (gnt & req) == '0) |=> (gnt == '0)); // R4

    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && req == '0) |=> (gnt == '0)); // R5
endmodule

bind bus_arbiter arb_checker #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .gnt(gnt)
);

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
    localparam int CLK_T = 10;
    localparam int N     = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [N-1:0] req = '0;
    logic         busy = 1'b0;
    logic [N-1:0] gnt;

    int total = 0;
    int bad = 0;
    int m_ptr = 0;
    int m_order [N];
    int wins [N];

    bus_arbiter #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .req(req), .busy(busy), .gnt(gnt)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_rot(input logic [N-1:0] r);
        for (int k = 0; k < N; k++) begin
            if (r[(m_ptr + k) % N]) return N'(1) << ((m_ptr + k) % N);
        end
        return '0;
    endfunction

    function automatic logic [N-1:0] exp_lru(input logic [N-1:0] r);
        for (int k = 0; k < N; k++) begin
            if (r[m_order[k]]) return N'(1) << m_order[k];
        end
        return '0;
    endfunction

    task automatic model_update(input logic [N-1:0] g);
        int gi = 0;
        int p = 0;
        for (int i = 0; i < N; i++) if (g[i]) gi = i;
        m_ptr = (m_ptr + N - 1) % N;
        for (int k = 0; k < N; k++) if (m_order[k] == gi) p = k;
        for (int k = p; k < N - 1; k++) m_order[k] = m_order[k+1];
        m_order[N-1] = gi;
    endtask

    // One full transaction: arbitrate, hold under busy, release.
    task automatic txn(input logic [N-1:0] r, input logic [1:0] m, input bit known,
                       input logic [N-1:0] exp, input string tag,
                       output logic [N-1:0] got);
        mode = m; req = r; busy = 1'b0;
        @(negedge clk);
        got = gnt;
        if (known) chk(gnt == exp, tag, gnt, exp);
        else chk($onehot(gnt) && ((gnt & r) != '0), {tag, " R2"}, gnt, r);
        busy = 1'b1; req = '0;
        @(negedge clk);
        chk(gnt == got, "R4 hold on busy", gnt, got);
        busy = 1'b0;
        @(negedge clk);
        chk(gnt == '0, "R4 release", gnt, '0);
        model_update(got);
    endtask

    initial begin
        #(CLK_T * 150000);
        bad++; total++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] g;
        logic [N-1:0] e;
        logic [N-1:0] seen;
        for (int i = 0; i < N; i++) begin m_order[i] = i; wins[i] = 0; end
        repeat (3) @(negedge clk);
        chk(gnt == '0, "R5 reset", gnt, '0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(gnt == '0, "R5 idle", gnt, '0);
        end

        // R6 rotating sweep, two passes over all patterns
        for (int p = 0; p < 2; p++) begin
            for (int r = 1; r < (1 << N); r++) begin
                e = exp_rot(N'(r));
                txn(N'(r), 2'b00, 1'b1, e, "R6 rotate", g);
            end
        end
        // R6 fairness with all requesting
        seen = '0;
        for (int k = 0; k < N; k++) begin
            e = exp_rot('1);
            txn('1, 2'b00, 1'b1, e, "R6 rotate all", g);
            seen = seen | g;
        end
        chk(seen == '1, "R6 each served once", seen, '1);

        // R7 LRU sweep
        for (int p = 0; p < 2; p++) begin
            for (int r = 1; r < (1 << N); r++) begin
                e = exp_lru(N'(r));
                txn(N'(r), 2'b01, 1'b1, e, "R7 lru", g);
            end
        end

        // R3 busy blocks arbitration
        mode = 2'b01; busy = 1'b1; req = '1;
        repeat (3) begin
            @(negedge clk);
            chk(gnt == '0, "R3 blocked by busy", gnt, '0);
        end
        e = exp_lru('1);
        busy = 1'b0;
        @(negedge clk);
        chk(gnt == e, "R3 grant after busy drops", gnt, e);
        // R4 hold while request stays high with busy low
        g = gnt;
        repeat (3) begin
            @(negedge clk);
            chk(gnt == g, "R4 hold on request", gnt, g);
        end
        req = '0;
        @(negedge clk);
        chk(gnt == '0, "R4 release on request drop", gnt, '0);
        model_update(g);

        // R8 random: single requests, then spread
        for (int i = 0; i < N; i++) begin
            txn(N'(1) << i, 2'b10, 1'b1, N'(1) << i, "R8 random single", g);
        end
        for (int k = 0; k < 400; k++) begin
            txn('1, 2'b10, 1'b0, '0, "R8 random all", g);
            for (int i = 0; i < N; i++) if (g[i]) wins[i]++;
        end
        for (int i = 0; i < N; i++) begin
            chk(wins[i] >= 50 && wins[i] <= 150, "R8 equal share",
                N'(wins[i] / 10), N'(10));
        end

        // R9 mode switch takes effect at next arbitration
        e = exp_rot(4'b0110);
        txn(4'b0110, 2'b00, 1'b1, e, "R9 switch to rotate", g);
        e = exp_lru(4'b1011);
        txn(4'b1011, 2'b01, 1'b1, e, "R9 switch to lru", g);
        e = exp_rot(4'b1101);
        txn(4'b1101, 2'b11, 1'b1, e, "R9 R6 code 11 rotates", g);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule